// File: doc/BRIEF.md
# Two-Deep Edge Capture Unit with Overwrite Guard

The unit timestamps input transitions on eight channels against a free-running 16-bit counter. Each channel has two storage slots: a primary capture slot and a secondary holding slot. When buffering is on, a new edge moves the older timestamp into the holding slot and writes the new one into the capture slot, all in one clock. A per-channel guard bit keeps unread timestamps from being replaced. Each slot is marked consumed when the bus reads it, and a capture slot is also marked consumed when its value moves to the holding slot.

A flag bit per channel reports new captures. With the pair-flag option set and the guard on, the flag is raised only once both slots hold unread data, so software services the channel once for every two events. Channels are grouped into pairs (0 with 4, 1 with 5, 2 with 6, 3 with 7). When the pair's link bit is set, the lower channel's pin and edge detector also drive the upper channel. A simple synchronous register bus reaches the timestamps and the configuration. The system control register can be written only once unless the special-mode input is high.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset every readable register (timestamps, edge select, flags, guard, system control) reads 0, and every slot is marked consumed.
- R2: The counter reads 0 in the first cycle after reset release and advances by 1 each clock (wrapping mod 2^16). A pin level driven during a cycle in which the counter is N is stored as timestamp N+2. The edge-select code per channel is 00 off, 01 rising, 10 falling, 11 both, held in bits [2k+1:2k] of the edge register.
- R3: With the guard bit of a channel set and buffering off, an edge does not replace an unread capture slot. Once the slot has been read, the next edge stores.
- R4: With the guard bit clear, every selected edge overwrites the capture slot.
- R5: With buffering on (system control bit 1) and the capture slot unread, an edge copies the capture slot into the holding slot and stores the new timestamp in the capture slot in the same cycle, provided the guard is clear or the holding slot is consumed. If the capture slot is consumed, the edge writes only the capture slot.
- R6: A capture slot counts as consumed after a bus read or after its value moves to the holding slot. A holding slot counts as consumed only after a bus read. With the guard set and both slots unread, both slots stay unchanged.
- R7: Every accepted capture sets the channel's flag (flag register bit k). Writing 1 to a flag bit clears it. A set and a clear in the same cycle leave the flag set.
- R8: With the pair-flag bit (system control bit 3) and the channel guard both set, an accepted capture raises the flag only if both slots are then unread. With the guard clear, every capture raises the flag.
- R9: Link bit 4+p of system control (p = 0..3) makes channel p+4 capture on the edges detected on channel p, using channel p's edge select. Channel p+4's own pin then has no effect.
- R10: When special_mode is low, the first write to system control takes effect and later writes are ignored. When special_mode is high, every write takes effect. Bits 2 and 0 are stored and read back.
- R11: Address map: capture slot k at k, holding slot k at 8+k, edge select at 16, flags at 17, guard bits at 18, system control at 19. A read (rd_en high) of a slot address marks that slot consumed at the next clock edge. rdata shows the addressed register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| special_mode | input | 1 | High allows unlimited writes to system control |
| cap_pin | input | 8 | Capture input pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; consumes the addressed slot |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |

## Verification
The assertions assume that every pin is low when reset releases, so that the synchronizers produce no spurious edge in the first cycles. They also assume that each read strobe names one address, so at most one slot is consumed per cycle. The stimulus holds all pins low through reset and changes one pin level at a time on a falling clock edge. Each level is held at least four cycles so that the capture settles before the bus looks at it. The sweep sets edge select, guard and system control only between events, never in the cycle a capture lands. The one deliberate overlap is the flag clear that coincides with a flag set.

// File: rtl/dcu_pkg.sv
`timescale 1ns/1ps
package dcu_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // system control bit positions
  localparam int SC_LATCH  = 0;
  localparam int SC_BUF    = 1;
  localparam int SC_ACCMUX = 2;
  localparam int SC_FMODE  = 3;
  localparam int SC_SHARE0 = 4;
endpackage

// File: rtl/dcu_edge.sv
`timescale 1ns/1ps
module dcu_edge
  import dcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       ev_o
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~prev_q;
    fall = ~s2_q & prev_q;
    case (edge_sel_e'(sel_i))
      EDGE_RISE: ev_o = rise;
      EDGE_FALL: ev_o = fall;
      EDGE_BOTH: ev_o = rise | fall;
      default:   ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcu_slot.sv
`timescale 1ns/1ps
module dcu_slot #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          event_i,
  input  logic          nov_i,
  input  logic          buf_en_i,
  input  logic          fmode_i,
  input  logic          rd_cap_i,
  input  logic          rd_hold_i,
  output logic [CW-1:0] cap_o,
  output logic [CW-1:0] hold_o,
  output logic          cap_empty_o,
  output logic          hold_empty_o,
  output logic          flag_set_o
);
  logic [CW-1:0] cap_q, cap_d, hold_q, hold_d;
  logic          cempty_q, cempty_d, hempty_q, hempty_d;
  logic          shift, cap_wr, both_full;

  always_comb begin
    shift     = buf_en_i && !cempty_q && (!nov_i || hempty_q);
    cap_wr    = event_i && (shift || !nov_i || cempty_q);
    both_full = shift || (!hempty_q && !rd_hold_i);
    cap_d      = cap_q;
    hold_d     = hold_q;
    cempty_d   = cempty_q | rd_cap_i;
    hempty_d   = hempty_q | rd_hold_i;
    flag_set_o = 1'b0;
    if (cap_wr) begin
      cap_d    = cnt_i;
      cempty_d = 1'b0;
      if (shift) begin
        hold_d   = cap_q;
        hempty_d = 1'b0;
      end
      flag_set_o = !(fmode_i && nov_i) || both_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      hold_q   <= '0;
      cempty_q <= 1'b1;
      hempty_q <= 1'b1;
    end else begin
      cap_q    <= cap_d;
      hold_q   <= hold_d;
      cempty_q <= cempty_d;
      hempty_q <= hempty_d;
    end
  end

  assign cap_o        = cap_q;
  assign hold_o       = hold_q;
  assign cap_empty_o  = cempty_q;
  assign hold_empty_o = hempty_q;
endmodule

// File: rtl/dual_capture_unit.sv
`timescale 1ns/1ps
module dual_capture_unit
  import dcu_pkg::*;
#(
  parameter  int NCH = 8,
  parameter  int CW  = 16,
  localparam int AW  = $clog2(2*NCH+4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           special_mode,
  input  logic [NCH-1:0] cap_pin,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata
);
  localparam int NPAIR = NCH / 2;
  localparam int SW    = SC_SHARE0 + NPAIR;
  localparam int EW    = 2 * NCH;
  localparam logic [AW-1:0] A_EDGE = AW'(2*NCH);
  localparam logic [AW-1:0] A_FLAG = AW'(2*NCH + 1);
  localparam logic [AW-1:0] A_NOVW = AW'(2*NCH + 2);
  localparam logic [AW-1:0] A_SYSC = AW'(2*NCH + 3);

  logic [CW-1:0]           cnt_q;
  logic [EW-1:0]           edge_q, edge_d;
  logic [NCH-1:0]          nov_q, nov_d, flags_q, flags_d, flag_clr;
  logic [SW-1:0]           sysc_q, sysc_d;
  logic                    lock_q, lock_d, sysc_wr;
  logic [NCH-1:0]          ev_raw, ev, rd_cap, rd_hold, flag_set;
  logic [NCH-1:0]          cap_empty, hold_empty;
  logic [NCH-1:0][CW-1:0]  cap_v, hold_v;

  // per-channel edge detection and storage
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dcu_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (cap_pin[k]),
      .sel_i (edge_q[2*k+1:2*k]),
      .ev_o  (ev_raw[k])
    );
    assign rd_cap[k]  = rd_en && (addr == AW'(k));
    assign rd_hold[k] = rd_en && (addr == AW'(NCH + k));
    dcu_slot #(.CW(CW)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .cnt_i        (cnt_q),
      .event_i      (ev[k]),
      .nov_i        (nov_q[k]),
      .buf_en_i     (sysc_q[SC_BUF]),
      .fmode_i      (sysc_q[SC_FMODE]),
      .rd_cap_i     (rd_cap[k]),
      .rd_hold_i    (rd_hold[k]),
      .cap_o        (cap_v[k]),
      .hold_o       (hold_v[k]),
      .cap_empty_o  (cap_empty[k]),
      .hold_empty_o (hold_empty[k]),
      .flag_set_o   (flag_set[k])
    );
  end

  // pair linking: lower channel's detected edge can drive the upper channel
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign ev[p]         = ev_raw[p];
    assign ev[p + NPAIR] = sysc_q[SC_SHARE0 + p] ? ev_raw[p] : ev_raw[p + NPAIR];
  end

  // register next state
  always_comb begin
    sysc_wr  = wr_en && (addr == A_SYSC);
    edge_d   = (wr_en && addr == A_EDGE) ? wdata[EW-1:0] : edge_q;
    nov_d    = (wr_en && addr == A_NOVW) ? wdata[NCH-1:0] : nov_q;
    flag_clr = (wr_en && addr == A_FLAG) ? wdata[NCH-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
    sysc_d   = (sysc_wr && (special_mode || !lock_q)) ? wdata[SW-1:0] : sysc_q;
    lock_d   = lock_q | (sysc_wr && !special_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      edge_q  <= '0;
      nov_q   <= '0;
      flags_q <= '0;
      sysc_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      edge_q  <= edge_d;
      nov_q   <= nov_d;
      flags_q <= flags_d;
      sysc_q  <= sysc_d;
      lock_q  <= lock_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == AW'(k))       rdata = cap_v[k];
      if (addr == AW'(NCH + k)) rdata = hold_v[k];
    end
    if (addr == A_EDGE) rdata = CW'(edge_q);
    if (addr == A_FLAG) rdata = CW'(flags_q);
    if (addr == A_NOVW) rdata = CW'(nov_q);
    if (addr == A_SYSC) rdata = CW'(sysc_q);
  end
endmodule

// File: rtl/dcu_chk.sv
`timescale 1ns/1ps
module dcu_chk
  import dcu_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int SW  = SC_SHARE0 + NCH/2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   special_mode,
  input logic                   lock_q,
  input logic [SW-1:0]          sysc_q,
  input logic [NCH-1:0]         nov_q,
  input logic [NCH-1:0][CW-1:0] cap_v,
  input logic [NCH-1:0][CW-1:0] hold_v,
  input logic [NCH-1:0]         cap_empty,
  input logic [NCH-1:0]         hold_empty,
  input logic [NCH-1:0]         ev,
  input logic [NCH-1:0]         rd_cap,
  input logic [NCH-1:0]         flags_q
);
  assert_sysc_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !special_mode) |=> $stable(sysc_q));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    assert_full_pair_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nov_q[k] && !cap_empty[k] && !hold_empty[k]) |=> ($stable(cap_v[k]) && $stable(hold_v[k])));

    assert_read_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cap[k] && !ev[k]) |=> cap_empty[k]);

    assert_flag_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[k]) |-> $past(ev[k]));

    assert_pair_flag_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags_q[k]) && $past(sysc_q[SC_FMODE] && nov_q[k])) |-> (!cap_empty[k] && !hold_empty[k]));
  end
endmodule

bind dual_capture_unit dcu_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .lock_q       (lock_q),
  .sysc_q       (sysc_q),
  .nov_q        (nov_q),
  .cap_v        (cap_v),
  .hold_v       (hold_v),
  .cap_empty    (cap_empty),
  .hold_empty   (hold_empty),
  .ev           (ev),
  .rd_cap       (rd_cap),
  .flags_q      (flags_q)
);

// File: tb/dual_capture_unit_tb_top.sv
`timescale 1ns/1ps
module dual_capture_unit_tb_top;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 5;
  localparam int A_EDGE = 16, A_FLAG = 17, A_NOVW = 18, A_SYSC = 19;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           special_mode;
  logic [NCH-1:0] cap_pin;
  logic           wr_en, rd_en;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  wdata;
  logic [CW-1:0]  rdata;

  int tc;
  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tc <= 0;
    else        tc <= (tc + 1) & 16'hFFFF;

  dual_capture_unit #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .cap_pin(cap_pin),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = CW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // drive a pin level; expected timestamp is counter now + 2
  task automatic pin(input int ch, input logic lvl, output int exp);
    @(negedge clk);
    cap_pin[ch] = lvl;
    exp = (tc + 2) & 16'hFFFF;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v, e1, e2, e3, e4;
    int model [NCH];
    rst_n = 1'b0; special_mode = 1'b1; cap_pin = '0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state over the whole map (R11)
    for (int a = 0; a < 20; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset addr %0d", a), v, 0);
    end
    for (int k = 0; k < NCH; k++) model[k] = 0;

    // R2 R4 R7 sweep: every channel x every edge code, guard clear, buffer off
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 4; m++) begin
        wr(A_EDGE, m << (2*ch));
        wr(A_FLAG, 8'hFF);
        pin(ch, 1'b1, e1);
        if (m == 1 || m == 3) model[ch] = e1;
        pin(ch, 1'b0, e2);
        if (m == 2 || m == 3) model[ch] = e2;
        rd(ch, v);
        chk($sformatf("R2 ch%0d code%0d timestamp", ch, m), v, model[ch]);
        rd(A_FLAG, v);
        chk($sformatf("R7 ch%0d code%0d flag", ch, m), v, (m != 0) ? (1 << ch) : 0);
      end
    end

    // R7 set wins over a same-cycle clear
    wr(A_EDGE, 16'h5555);
    wr(A_FLAG, 8'hFF);
    @(negedge clk);
    cap_pin[0] = 1'b1;
    e1 = (tc + 2) & 16'hFFFF;
    @(negedge clk);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v);
    chk("R7 set beats clear", v & 1, 1);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v);
    chk("R7 write-one clears", v & 1, 0);
    pin(0, 1'b0, e2);
    rd(0, v);
    chk("R2 timestamp at set/clear", v, e1);

    // R3 guard with buffer off on channel 0 (cap0 consumed by read above)
    wr(A_NOVW, 8'h01);
    pin(0, 1'b1, e1); pin(0, 1'b0, e2);
    pin(0, 1'b1, e3); pin(0, 1'b0, e2);
    rd(0, v);
    chk("R3 guarded slot kept", v, e1);
    pin(0, 1'b1, e4); pin(0, 1'b0, e2);
    rd(0, v);
    chk("R3 stores after read", v, e4);

    // R4 unguarded overwrite on channel 1
    pin(1, 1'b1, e1); pin(1, 1'b0, e2);
    pin(1, 1'b1, e3); pin(1, 1'b0, e2);
    rd(1, v);
    chk("R4 overwrite without read", v, e3);

    // R5 R6 buffering with guard on channel 2
    wr(A_SYSC, 8'h02);
    wr(A_NOVW, 8'h04);
    pin(2, 1'b1, e1); pin(2, 1'b0, v);
    pin(2, 1'b1, e2); pin(2, 1'b0, v);
    pin(2, 1'b1, e3); pin(2, 1'b0, v);
    rd(10, v);
    chk("R6 holding keeps first while full", v, e1);
    pin(2, 1'b1, e4); pin(2, 1'b0, v);
    rd(2, v);
    chk("R5 capture after shift", v, e4);
    rd(10, v);
    chk("R5 R6 shifted value, blocked edge dropped", v, e2);

    // R8 pair flag: channel 3 guarded, channel 4 unguarded
    wr(A_SYSC, 8'h0A);
    wr(A_NOVW, 8'h08);
    wr(A_FLAG, 8'hFF);
    pin(3, 1'b1, e1); pin(3, 1'b0, v);
    rd(A_FLAG, v);
    chk("R8 no flag after one capture", v & 8'h08, 0);
    pin(3, 1'b1, e2); pin(3, 1'b0, v);
    rd(A_FLAG, v);
    chk("R8 flag after two captures", v & 8'h08, 8'h08);
    rd(11, v);
    chk("R8 holding value", v, e1);
    pin(4, 1'b1, e3); pin(4, 1'b0, v);
    rd(A_FLAG, v);
    chk("R8 unguarded flags each capture", v & 8'h10, 8'h10);

    // R9 pair link 1 -> 5; channel 5 edge code off
    wr(A_SYSC, 8'h20);
    wr(A_NOVW, 8'h00);
    wr(A_EDGE, 16'h5155);
    wr(A_FLAG, 8'hFF);
    pin(1, 1'b1, e1);
    rd(5, v);
    chk("R9 linked capture on ch5", v, e1);
    rd(1, v);
    chk("R9 ch1 own capture", v, e1);
    wr(A_FLAG, 8'hFF);
    pin(5, 1'b1, e2); pin(5, 1'b0, e3);
    rd(5, v);
    chk("R9 ch5 pin ignored", v, e1);
    rd(A_FLAG, v);
    chk("R9 no flag from ch5 pin", v & 8'h20, 0);
    pin(1, 1'b0, v);

    // R10 write-once in normal mode
    special_mode = 1'b0;
    wr(A_SYSC, 8'h05);
    rd(A_SYSC, v);
    chk("R10 first write", v, 8'h05);
    wr(A_SYSC, 8'hF0);
    rd(A_SYSC, v);
    chk("R10 second write ignored", v, 8'h05);
    special_mode = 1'b1;
    wr(A_SYSC, 8'h00);
    rd(A_SYSC, v);
    chk("R10 special mode rewrite", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule